// File: doc/BRIEF.md
# Bar-Graph LED Matrix Packet Writer

This block drives a register-addressed 8x8 LED matrix controller over a one-way serial link: clock, data and an active-low load strobe. Every transfer is a 16-bit word, a register address byte followed by a data byte, sent most significant bit first. Data changes while the serial clock is low and is valid on its rising edge. The load strobe falls before the first clock pulse and rises after the last one. A fixed quiet time follows before the next word.

After reset the block sends a fixed set-up sequence on its own. Once that is done it waits for `frame_valid`. That pulse captures eight 8-bit band magnitudes. Each band is turned into a bar: a row pattern with one more lit LED for every step of 32. The bar is rotated right by one bit to undo a one-position wiring offset on the matrix. The block then writes all eight rows in order. A frame that arrives while the block is busy is held and sent when the current sequence ends. Only the newest such frame is kept.

Top module: `ledmat_frame_writer`

## Requirements
- R1: Each word is 16 bits, address byte then data byte, MSB first. `mosi` holds steady while `sck` is high. Exactly 16 `sck` rising edges occur while `load_n` is low, and `sck` rests low.
- R2: `sck` stays high for exactly SCK_DIV clock cycles and low for exactly SCK_DIV cycles between rising edges. The first rising edge comes SCK_DIV cycles after `load_n` falls. The default of 25 gives 1 MHz from a 50 MHz clock.
- R3: `load_n` rises 2*SCK_DIV cycles after the final `sck` rising edge. `sck` never rises while `load_n` is high. Between two words of one sequence, `load_n` stays high for exactly GAP_CYC cycles.
- R4: After reset, these words are sent in this order: 0x0C01, 0x0900, 0x0A0F, 0x0B07, 0x0F00, and then 0x0100, 0x0200 and so on up to 0x0800.
- R5: After the first set-up word (0x0C01), `load_n` stays high for exactly WAKE_CYC cycles before the next word.
- R6: A band magnitude m becomes a bar of (m/32)+1 lit bits filled from bit 0: m<32 gives 0x01, m<64 gives 0x03, and so on, up to m>=224 giving 0xFF.
- R7: Only words with address 0x01 to 0x08 have their data byte rotated right by one: new bit 7 is old bit 0, and new bits 6..0 are old bits 7..1. Set-up words with other addresses are sent unchanged, so 0x0A0F stays 0x0A0F.
- R8: A refresh sends eight words. Band i is taken from `mags[8*i+7:8*i]` and goes to address i+1, for i = 0 up to 7 in that order.
- R9: `frame_valid` is captured with `mags` in every cycle it is high, including during set-up or a refresh. A held frame starts right after the current sequence's last quiet time, with no idle cycle in between. Several frames captured during one sequence lead to a single refresh that uses the newest `mags`.
- R10: `busy` is high from the first `load_n` fall of a sequence until the quiet time after its last word ends. When the block is idle, `load_n` falls on the second rising clock edge counted from the edge that samples `frame_valid`.
- R11: While reset is held, `load_n` is 1 and `sck`, `mosi` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Capture `mags` and request a refresh |
| mags | input | 64 | Eight band magnitudes, band i in bits 8i+7..8i |
| sck | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data, MSB first |
| load_n | output | 1 | Active-low load strobe framing each word |
| busy | output | 1 | High while a sequence is in progress |

## Verification
Every serial result comes back on a fixed cycle count. The first `sck` rise is SCK_DIV cycles after `load_n` falls. Rises are then 2*SCK_DIV apart, each high phase lasts SCK_DIV, and `load_n` rises 2*SCK_DIV after the sixteenth rise. The quiet time is GAP_CYC cycles, or WAKE_CYC cycles after the shutdown-exit word. A monitor samples on the falling clock edge and stamps every edge of `sck`, `load_n` and `busy` with a cycle number, then compares each interval with these exact counts. For the start-up latency, `load_n` is checked twice: high one sample after the `frame_valid` pulse and low one sample later. Decoded words are compared only once `busy` has fallen after the expected word count.

// File: rtl/ledmat_frame_writer.sv
module ledmat_frame_writer #(
  parameter int SCK_DIV  = 25,
  parameter int GAP_CYC  = 100,
  parameter int WAKE_CYC = 15000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_valid,
  input  logic [63:0] mags,
  output logic        sck,
  output logic        mosi,
  output logic        load_n,
  output logic        busy
);

  localparam int MX1  = (WAKE_CYC > GAP_CYC) ? WAKE_CYC : GAP_CYC;
  localparam int MAXC = (MX1 > SCK_DIV) ? MX1 : SCK_DIV;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int NSET = 13;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_TAIL, S_GAP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [3:0]   bcnt;
  logic [15:0]  sr;
  logic         sck_q, ld_q;
  logic         seq_ref;
  logic [3:0]   idx;
  logic         init_pend, frame_pend;
  logic [63:0]  pend_mags, cur_mags;

  logic         go, start_ref, start_init, last;
  logic         n_seq;
  logic [3:0]   n_idx;
  logic [63:0]  src;
  logic [7:0]   band, bar;
  logic [15:0]  raw, word;
  logic         rot_en;

  function automatic logic [15:0] setup_word(input logic [3:0] i);
    case (i)
      4'd0:    setup_word = 16'h0C01;
      4'd1:    setup_word = 16'h0900;
      4'd2:    setup_word = 16'h0A0F;
      4'd3:    setup_word = 16'h0B07;
      4'd4:    setup_word = 16'h0F00;
      default: setup_word = {4'h0, i - 4'd4, 8'h00};
    endcase
  endfunction

  assign last = seq_ref ? (idx == 4'd7) : (idx == 4'(NSET - 1));

  always_comb begin
    go = 1'b0; start_ref = 1'b0; start_init = 1'b0;
    n_seq = seq_ref; n_idx = idx;
    if (st == S_IDLE || (st == S_GAP && cnt == '0)) begin
      if (st == S_GAP && !last) begin
        go = 1'b1; n_idx = idx + 4'd1;
      end else if (init_pend) begin
        go = 1'b1; start_init = 1'b1; n_seq = 1'b0; n_idx = 4'd0;
      end else if (frame_pend) begin
        go = 1'b1; start_ref = 1'b1; n_seq = 1'b1; n_idx = 4'd0;
      end
    end
  end

  assign src  = start_ref ? pend_mags : cur_mags;
  assign band = src[{n_idx[2:0], 3'b000} +: 8];

  assign bar[0] = 1'b1;
  for (genvar j = 1; j < 8; j++) begin : g_bar
    assign bar[j] = (band[7:5] >= 3'(j));
  end

  assign raw    = n_seq ? {4'h0, n_idx + 4'd1, bar} : setup_word(n_idx);
  assign rot_en = (raw[15:8] >= 8'h01) && (raw[15:8] <= 8'h08);
  assign word   = rot_en ? {raw[15:8], raw[0], raw[7:1]} : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_pend <= 1'b0;
      pend_mags  <= '0;
    end else begin
      if (start_ref) frame_pend <= 1'b0;
      if (frame_valid) begin
        frame_pend <= 1'b1;
        pend_mags  <= mags;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bcnt      <= '0;
      sr        <= '0;
      sck_q     <= 1'b0;
      ld_q      <= 1'b1;
      seq_ref   <= 1'b0;
      idx       <= '0;
      init_pend <= 1'b1;
      cur_mags  <= '0;
    end else begin
      case (st)
        S_IDLE, S_GAP: begin
          if (go) begin
            st      <= S_LO;
            ld_q    <= 1'b0;
            sr      <= word;
            bcnt    <= '0;
            cnt     <= CW'(SCK_DIV - 1);
            seq_ref <= n_seq;
            idx     <= n_idx;
            if (start_init) init_pend <= 1'b0;
            if (start_ref)  cur_mags  <= pend_mags;
          end else if (st == S_GAP) begin
            if (cnt == '0) st <= S_IDLE;
            else           cnt <= cnt - 1'b1;
          end
        end
        S_LO: begin
          if (cnt == '0) begin
            st    <= S_HI;
            sck_q <= 1'b1;
            cnt   <= CW'(SCK_DIV - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_HI: begin
          if (cnt == '0) begin
            sck_q <= 1'b0;
            cnt   <= CW'(SCK_DIV - 1);
            if (bcnt == 4'd15) st <= S_TAIL;
            else begin
              st   <= S_LO;
              sr   <= {sr[14:0], 1'b0};
              bcnt <= bcnt + 4'd1;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_TAIL: begin
          if (cnt == '0) begin
            st   <= S_GAP;
            ld_q <= 1'b1;
            cnt  <= (!seq_ref && idx == 4'd0) ? CW'(WAKE_CYC - 1) : CW'(GAP_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sck    = sck_q;
  assign mosi   = sr[15];
  assign load_n = ld_q;
  assign busy   = (st != S_IDLE);

  AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) ld_q |-> !sck_q); // R3
  AST_BUSY_COVERS_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !ld_q |-> busy); // R10
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck_q && $past(sck_q)) |-> $stable(mosi)); // R1
  AST_SCK_EDGE_ON_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n) (sck_q != $past(sck_q)) |-> ($past(cnt) == '0)); // R2
  AST_SIXTEEN_BITS: assert property (@(posedge clk) disable iff (!rst_n) $rose(ld_q) |-> ($past(bcnt) == 4'd15)); // R1
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |=> frame_pend); // R9
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ld_q) && $past(init_pend)) |-> (sr[15:8] == 8'h0C)); // R4

endmodule

// File: tb/sim_ledmat_frame_writer.sv
module sim_ledmat_frame_writer;
  localparam int DIV  = 25;
  localparam int GAP  = 100;
  localparam int WAKE = 15000;

  logic clk = 1'b0, rst_n = 1'b0, fv = 1'b0;
  logic [63:0] mags = '0;
  logic sck, mosi, load_n, busy;

  ledmat_frame_writer #(.SCK_DIV(DIV), .GAP_CYC(GAP), .WAKE_CYC(WAKE)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_valid(fv), .mags(mags),
    .sck(sck), .mosi(mosi), .load_n(load_n), .busy(busy));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int pkt_n = 0, bits = 0, fall_c = 0, rise_c = 0, lastr = 0, tail = 0;
  logic [15:0] shv = '0;
  logic [15:0] pkts [128];
  int gaps [128];
  logic p_ld = 1'b1, p_sck = 1'b0, p_busy = 1'b0, first = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_bar(input logic [7:0] m);
    logic [8:0] t;
    t = (9'd2 << m[7:5]) - 9'd1;
    return t[7:0];
  endfunction

  function automatic logic [15:0] ref_row(input int i, input logic [7:0] m);
    logic [7:0] b;
    b = ref_bar(m);
    return {8'(i + 1), b[0], b[7:1]};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (p_ld && !load_n) begin
          bits = 0; shv = '0; fall_c = cyc; first = 1'b1;
          if (pkt_n < 128) gaps[pkt_n] = cyc - rise_c;
        end
        if (!p_sck && sck) begin
          chk(!load_n, "R3 sck rise while deselected", 1, 0);
          if (first) chk((cyc - fall_c) == DIV, "R2 first rise delay", cyc - fall_c, DIV);
          else       chk((cyc - lastr) == 2*DIV, "R2 rise spacing", cyc - lastr, 2*DIV);
          first = 1'b0; lastr = cyc; shv = {shv[14:0], mosi}; bits++;
        end
        if (p_sck && !sck) chk((cyc - lastr) == DIV, "R2 high time", cyc - lastr, DIV);
        if (!p_ld && load_n) begin
          chk(bits == 16, "R1 bits per word", bits, 16);
          chk((cyc - lastr) == 2*DIV, "R3 load rise delay", cyc - lastr, 2*DIV);
          if (pkt_n < 128) pkts[pkt_n] = shv;
          pkt_n++; rise_c = cyc;
        end
        if (p_busy && !busy) tail = cyc - rise_c;
      end
      p_ld = load_n; p_sck = sck; p_busy = busy;
    end
  end

  task automatic wait_done(input int target);
    int t = 0;
    while (!(pkt_n >= target && !busy)) begin
      @(negedge clk);
      t++;
      if (t > 60000) begin
        chk(0, "watchdog wait", pkt_n, target);
        break;
      end
    end
  endtask

  task automatic pulse(input logic [63:0] m);
    @(negedge clk); mags = m; fv = 1'b1;
    @(negedge clk); fv = 1'b0;
  endtask

  task automatic cmp_rows(input int base, input logic [63:0] m, input string tag);
    for (int i = 0; i < 8; i++)
      chk(pkts[base + i] == ref_row(i, m[8*i +: 8]), tag, pkts[base + i], ref_row(i, m[8*i +: 8]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(load_n == 1'b1, "R11 load_n in reset", load_n, 1);
    chk(sck == 1'b0, "R11 sck in reset", sck, 0);
    chk(mosi == 1'b0, "R11 mosi in reset", mosi, 0);
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_setup_with_early_frame();
    logic [15:0] exp_s [13];
    logic [63:0] a;
    exp_s[0] = 16'h0C01; exp_s[1] = 16'h0900; exp_s[2] = 16'h0A0F;
    exp_s[3] = 16'h0B07; exp_s[4] = 16'h0F00;
    for (int i = 0; i < 8; i++) exp_s[5 + i] = {8'(i + 1), 8'h00};
    for (int i = 0; i < 8; i++) a[8*i +: 8] = 8'(30*i + 5);
    repeat (600) @(negedge clk);
    pulse(a);
    wait_done(21);
    for (int i = 0; i < 13; i++) chk(pkts[i] == exp_s[i], "R4 R7 setup word", pkts[i], exp_s[i]);
    chk(gaps[1] == WAKE, "R5 wake gap", gaps[1], WAKE);
    for (int i = 2; i < 13; i++) chk(gaps[i] == GAP, "R3 quiet time", gaps[i], GAP);
    chk(gaps[13] == GAP, "R9 held frame chained", gaps[13], GAP);
    cmp_rows(13, a, "R9 R8 frame captured during setup");
    chk(tail == GAP, "R10 busy after last word", tail, GAP);
  endtask

  task automatic t_frame(input logic [63:0] m, input string tag);
    int base = pkt_n;
    @(negedge clk); mags = m; fv = 1'b1;
    @(negedge clk); fv = 1'b0;
    chk(load_n == 1'b1, "R10 not yet selected", load_n, 1);
    @(negedge clk);
    chk(load_n == 1'b0 && busy == 1'b1, "R10 start latency", {load_n, busy}, 2'b01);
    wait_done(base + 8);
    cmp_rows(base, m, tag);
    for (int i = 1; i < 8; i++) chk(gaps[base + i] == GAP, "R3 refresh quiet time", gaps[base + i], GAP);
    chk(tail == GAP, "R10 busy tail", tail, GAP);
  endtask

  task automatic t_newest_wins();
    logic [63:0] b = 64'h10_30_50_70_90_B0_D0_F0;
    logic [63:0] c = 64'hFF_FF_FF_FF_FF_FF_FF_FF;
    logic [63:0] d = 64'h00_E0_1F_C0_3F_A0_5F_80;
    int base = pkt_n;
    pulse(b);
    while (pkt_n < base + 2) @(negedge clk);
    pulse(c);
    repeat (300) @(negedge clk);
    pulse(d);
    wait_done(base + 16);
    cmp_rows(base, b, "R8 first refresh");
    cmp_rows(base + 8, d, "R9 newest frame kept");
    chk(gaps[base + 8] == GAP, "R9 chained without idle", gaps[base + 8], GAP);
    repeat (500) @(negedge clk);
    chk(pkt_n == base + 16 && !busy, "R9 single extra refresh", pkt_n - base, 16);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] lo_edges, hi_edges;
    for (int i = 0; i < 8; i++) begin
      lo_edges[8*i +: 8] = 8'(32*i);
      hi_edges[8*i +: 8] = 8'(32*i + 31);
    end
    t_reset();
    t_setup_with_early_frame();
    t_frame(64'h0, "R6 R7 all zero");
    t_frame({8{8'hFF}}, "R6 R7 all full");
    t_frame(lo_edges, "R6 R7 lower step edges");
    t_frame(hi_edges, "R6 R7 upper step edges");
    t_frame(64'h01_FE_20_DF_5A_9C_7F_E0, "R6 R8 mixed bands");
    t_newest_wins();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule